// File: doc/BRIEF.md
# Serial-Bus Wiper Register Slave

This block is the digital front end of a 128-step digital potentiometer. It listens on a two-wire I2C bus as a slave, owns a single 7-bit wiper code and presents that code to the tap-select logic of the resistor ladder. There is no command byte and no register pointer. Every data byte written to the slave replaces the wiper code, and every byte read from it returns the current code.

SCL and SDA are oversampled by a system clock at least eight times faster than SCL. Each line passes through a two-flop synchroniser. START is a falling SDA with SCL high, and STOP is a rising SDA with SCL high; both are decoded from the synchronised samples. The slave pulls SDA low through an open-drain enable and never stretches the clock.

A brown-out condition is modelled as the active-high `bor` input. While `bor` is high, the interface stays idle and the wiper is held at mid-scale.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 40h (mid-scale) and `sda_oe` is 0.
- R2: After a START, the slave acknowledges a control byte whose upper seven bits are 0101111, sent MSB first, by pulling SDA low in the ninth clock. The eighth bit selects the direction: 0 is a write and 1 is a read.
- R3: A control byte with any other address is not acknowledged. After it, the slave leaves SDA released for all following bytes until the next START, and the wiper is unchanged.
- R4: In a write, every data byte is acknowledged. Bits 6..0 of each byte become the wiper code and bit 7 is ignored. Any number of bytes may follow one control byte.
- R5: The wiper changes only while SCL is high in the acknowledge clock of a complete data byte. A byte cut short by a START or a STOP leaves the wiper unchanged.
- R6: In a read, the slave sends the byte {0, wiper code} MSB first. It sends the same byte again after every byte the master acknowledges.
- R7: After the master does not acknowledge a read byte, the slave keeps SDA released until the next START.
- R8: A START in any state, including a repeated START with no STOP before it, restarts the control-byte phase.
- R9: While `bor` is high, the slave gives no acknowledge and drives no SDA, and the wiper is held at 40h. After `bor` falls, normal operation resumes.
- R10: `sda_oe` changes only while SCL is low, never during an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bor | input | 1 | Brown-out hold, active high |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| wiper_code | output | 7 | Current wiper tap code (00h zero scale, 7Fh full scale) |

## Verification
The assertions check four things on every clock: SDA is only driven in an acknowledge or read-data state, SDA drive and wiper changes happen in the correct SCL phase, and brown-out forces mid-scale with SDA released. Only the bench scenarios can show the rest. That covers address matching and its NACK, the exact bytes returned in a streamed read, the 7-bit masking of written data, and aborts by START or STOP in mid-byte. It also covers the release of SDA after a master NACK. The bench keeps a model of the wiper code that is updated from the transactions it drives, and compares it with the output on every clock.

// File: rtl/wi2c_pkg.sv
package wi2c_pkg;
  localparam int unsigned WIPER_W_DEF = 7;
  localparam logic [6:0]  DEV_ADDR_DEF = 7'b0101111;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_WR_DATA  = 3'd3,
    ST_WR_ACK   = 3'd4,
    ST_RD_DATA  = 3'd5,
    ST_RD_ACK   = 3'd6,
    ST_IGNORE   = 3'd7
  } wi2c_state_t;
endpackage

// File: rtl/wi2c_sync.sv
// Multi-stage synchroniser; resets to 1 (idle bus level).
module wi2c_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wi2c_bus_events.sv
// Edge and bus-condition decode from synchronised SCL/SDA.
module wi2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/wi2c_proto.sv
// Protocol engine: control byte, write bytes, streamed read.
module wi2c_proto
  import wi2c_pkg::*;
#(
  parameter int unsigned WIPER_W  = WIPER_W_DEF,
  parameter logic [6:0]  DEV_ADDR = DEV_ADDR_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bor,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [WIPER_W-1:0] wiper_q,
  output logic               sda_oe,
  output logic               wr_en,
  output logic [WIPER_W-1:0] wr_data,
  output wi2c_state_t        state_o
);
  localparam int unsigned BYTE_W = WIPER_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  wi2c_state_t       state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              oe_q, oe_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    if (bor) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_ev) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            rx_n  = {rx_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == CNT_FULL) begin
            if (state_q == ST_WR_DATA) begin
              oe_n    = 1'b1;
              state_n = ST_WR_ACK;
            end else if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
              rw_n    = rx_q[0];
              oe_n    = 1'b1;
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              tx_n    = {1'b0, wiper_q};
              oe_n    = 1'b1;
              state_n = ST_RD_DATA;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_WR_DATA;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_rise) wr_en = 1'b1;
          if (scl_fall) begin
            oe_n    = 1'b0;
            cnt_n   = '0;
            state_n = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise) cnt_n = cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              oe_n    = 1'b0;
              state_n = ST_RD_ACK;
            end else begin
              tx_n = {tx_q[BYTE_W-2:0], 1'b0};
              oe_n = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_n    = {1'b0, wiper_q};
              oe_n    = 1'b1;
              cnt_n   = '0;
              state_n = ST_RD_DATA;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_data = rx_q[WIPER_W-1:0];
  assign state_o = state_q;
endmodule

// File: rtl/wi2c_wiper.sv
// Wiper code storage, mid-scale on reset and during brown-out.
module wi2c_wiper #(
  parameter int unsigned WIPER_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bor,
  input  logic               wr_en,
  input  logic [WIPER_W-1:0] wr_data,
  output logic [WIPER_W-1:0] wiper_q
);
  localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

  logic [WIPER_W-1:0] wiper_n;

  always_comb begin
    wiper_n = wiper_q;
    if (bor)        wiper_n = MID;
    else if (wr_en) wiper_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= MID;
    else        wiper_q <= wiper_n;
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wi2c_pkg::*;
#(
  parameter int unsigned WIPER_W     = WIPER_W_DEF,
  parameter logic [6:0]  DEV_ADDR    = DEV_ADDR_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bor,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper_code
);
  logic [1:0]         pins_s;
  logic               scl_s, sda_s;
  logic               scl_rise, scl_fall, start_ev, stop_ev;
  logic               wr_en;
  logic [WIPER_W-1:0] wr_data;
  wi2c_state_t        st;
  logic [2:0]         fsm_state;

  wi2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  wi2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  wi2c_proto #(.WIPER_W(WIPER_W), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .bor(bor), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .wiper_q(wiper_code), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_data(wr_data), .state_o(st)
  );

  wi2c_wiper #(.WIPER_W(WIPER_W)) u_wiper (
    .clk(clk), .rst_n(rst_n), .bor(bor),
    .wr_en(wr_en), .wr_data(wr_data), .wiper_q(wiper_code)
  );

  assign fsm_state = st;
endmodule

// File: rtl/wiper_i2c_slave_chk.sv
module wiper_i2c_slave_chk
  import wi2c_pkg::*;
#(
  parameter int unsigned WIPER_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bor,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [WIPER_W-1:0] wiper_code,
  input logic [2:0]         fsm_state
);
  localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

  assert_bor_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bor |=> (wiper_code == MID));

  assert_bor_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bor |=> !sda_oe);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bor && !$past(bor) && (sda_oe != $past(sda_oe))) |-> !scl_i);

  assert_wiper_ack_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bor && !$past(bor) && (wiper_code != $past(wiper_code))) |-> scl_i);

  assert_drive_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (fsm_state == 3'(ST_ADDR_ACK) || fsm_state == 3'(ST_WR_ACK) ||
                fsm_state == 3'(ST_RD_DATA)));

  assert_ignore_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 3'(ST_IGNORE)) |-> !sda_oe);
endmodule

bind wiper_i2c_slave wiper_i2c_slave_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bor(bor), .scl_i(scl_i), .sda_oe(sda_oe),
  .wiper_code(wiper_code), .fsm_state(fsm_state)
);

// File: tb/wiper_i2c_slave_test.sv
module wiper_i2c_slave_test;
  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst_n, bor, scl, md_low;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] wiper_code;

  int         n_run = 0;
  int         n_fail = 0;
  int         pend_cnt = 0;
  logic [6:0] pend_val;
  logic [6:0] model_w;
  logic [7:0] rd;
  logic       ak;

  always #10 clk = ~clk;

  assign sda_line = !(md_low || sda_oe);

  wiper_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .bor(bor), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper_code(wiper_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Per-clock reference of the wiper code (R4 R5 R9)
  always @(posedge clk) begin
    #2;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) model_w = pend_val;
    end
    if (rst_n === 1'b1) begin
      n_run++;
      if (wiper_code !== model_w) begin
        n_fail++;
        $display("FAIL R5 per-clock wiper: got %0h expected %0h", wiper_code, model_w);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    md_low = 1'b0; tick(Q);
    scl = 1'b1;    tick(Q);
    md_low = 1'b1; tick(Q);
    scl = 1'b0;    tick(Q);
  endtask

  task automatic bus_stop();
    md_low = 1'b1; tick(Q);
    scl = 1'b1;    tick(Q);
    md_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    md_low = !b; tick(Q);
    scl = 1'b1;  tick(2*Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic get_bit(output logic b, input logic upd, input logic [6:0] val);
    logic b2;
    md_low = 1'b0; tick(Q);
    scl = 1'b1;
    if (upd) begin pend_val = val; pend_cnt = 3; end
    tick(Q);
    b = sda_line;
    tick(Q - 1);
    b2 = sda_line;
    chk("R10 sda stable while scl high", b2, b);
    tick(1);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic upd, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a, upd, v[6:0]);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b, 1'b0, 7'h0);
      v[i] = b;
    end
    send_bit(!mack);
  endtask

  initial begin
    rst_n = 1'b0; bor = 1'b0; scl = 1'b1; md_low = 1'b0;
    model_w = 7'h40; pend_val = 7'h40;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset wiper", wiper_code, 7'h40);
    chk("R1 reset sda_oe", sda_oe, 0);

    // Multi-byte write, MSB ignored
    bus_start();
    send_byte(8'h5E, 1'b0, ak); chk("R2 address ack (write)", ak, 0);
    send_byte(8'h15, 1'b1, ak); chk("R4 data ack 1", ak, 0);
    chk("R4 wiper after 15h", wiper_code, 7'h15);
    send_byte(8'hFF, 1'b1, ak); chk("R4 data ack 2", ak, 0);
    chk("R4 bit7 ignored FFh", wiper_code, 7'h7F);
    send_byte(8'h80, 1'b1, ak); chk("R4 data ack 3", ak, 0);
    bus_stop();
    chk("R4 bit7 ignored 80h", wiper_code, 7'h00);

    // Wrong address
    bus_start();
    send_byte(8'h5C, 1'b0, ak); chk("R3 foreign address nack", ak, 1);
    send_byte(8'h33, 1'b0, ak); chk("R3 ignored byte nack", ak, 1);
    bus_stop();
    chk("R3 wiper unchanged", wiper_code, 7'h00);

    // Write then repeated START read, streamed
    bus_start();
    send_byte(8'h5E, 1'b0, ak);
    send_byte(8'h2A, 1'b1, ak);
    bus_start();
    send_byte(8'h5F, 1'b0, ak); chk("R8 repeated start read ack", ak, 0);
    read_byte(1'b1, rd); chk("R6 read byte 1", rd, 8'h2A);
    read_byte(1'b1, rd); chk("R6 read byte 2", rd, 8'h2A);
    read_byte(1'b0, rd); chk("R6 read byte 3", rd, 8'h2A);
    get_bit(ak, 1'b0, 7'h0); chk("R7 released after nack", ak, 1);
    chk("R7 sda_oe low", sda_oe, 0);
    bus_stop();

    // Partial byte aborted by START
    bus_start();
    send_byte(8'h5E, 1'b0, ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    chk("R5 partial byte + START", wiper_code, 7'h2A);
    send_byte(8'h5E, 1'b0, ak); chk("R8 start after abort ack", ak, 0);
    send_byte(8'h11, 1'b1, ak);
    // Partial byte aborted by STOP
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    chk("R5 partial byte + STOP", wiper_code, 7'h11);

    // Brown-out
    bor = 1'b1; pend_val = 7'h40; pend_cnt = 1;
    tick(3);
    chk("R9 bor mid-scale", wiper_code, 7'h40);
    bus_start();
    send_byte(8'h5E, 1'b0, ak); chk("R9 no ack in bor", ak, 1);
    send_byte(8'h05, 1'b0, ak);
    bus_stop();
    chk("R9 wiper held", wiper_code, 7'h40);
    bor = 1'b0;
    tick(3);
    bus_start();
    send_byte(8'h5E, 1'b0, ak); chk("R9 ack after bor release", ak, 0);
    send_byte(8'h55, 1'b1, ak);
    bus_start();
    send_byte(8'h5F, 1'b0, ak);
    read_byte(1'b0, rd); chk("R6 read 55h", rd, 8'h55);
    bus_stop();
    chk("R1 sda_oe idle at end", sda_oe, 0);

    tick(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule